// File: doc/BRIEF.md
# Latency-Aware Issue Interlock

This block decides, cycle by cycle, whether the instruction waiting at the issue point of an in-order, single-issue, five-stage pipeline may issue. The pipeline has floating-point units. The decode stage gives the block the instruction's class, its destination register and two source registers. The block keeps a small table of producers that are still in flight. Each entry records the register a producer writes, the producer's class and a down-counter.

The gap required between a producer and its consumer depends on the pair of classes involved and on how the consumer uses the operand. A value used as a store's data may arrive later than a value used as an arithmetic input or as an address. The block therefore looks up a fixed pairwise latency table rather than applying one load-use rule.

When a hazard exists, the waiting instruction is held at its stage and a bubble goes down the pipe. Issue is only allowed once enough cycles have passed since the producer issued. The functional units are fully pipelined, so independent instructions issue back to back.

Top module: `ilk_issue_interlock`

## Requirements
- R1: An FP ALU result read as a source by a later FP ALU operation forces that consumer to issue no earlier than 4 cycles after the producer. An adjacent pair therefore stalls 3 cycles, and a pair with one unrelated instruction between them stalls 2 cycles.
- R2: An FP ALU result used as a store's data operand needs a gap of 2 stall cycles when the two instructions are adjacent. It needs 1 stall cycle when one instruction separates them.
- R3: A load result read by an FP ALU operation, or by any other non-store-data operand, needs 1 stall cycle when the two instructions are adjacent.
- R4: A load result used as a store's data operand never stalls the store.
- R5: A store's address operand (src_a) uses the producer-to-arithmetic latency, not the store-data latency. For example, a load followed at once by a store whose address is the loaded register stalls 1 cycle.
- R6: Integer and branch producers never cause a stall. The instruction right after a branch issues in the next cycle.
- R7: The integer register 0 (specifier 6'd0) never creates a dependence, whether it appears as a destination or as a source.
- R8: Independent instructions issue on consecutive cycles with no stall.
- R9: When two in-flight producers write the same register, only the newest one decides the stall of a later reader.
- R10: `stall` can only be high while `in_valid` is high, and `issue` equals `in_valid` and not `stall`. A stalled instruction stays at the input and is judged again every cycle.
- R11: A synchronous active-low reset empties the producer table. In the first cycle after reset no instruction stalls, and with `in_valid` low both outputs are low.
- R12: A load reads only src_a (its address base). Its src_b never causes a stall.

Class codes on `in_cls` are: 0 integer, 1 FP ALU, 2 load, 3 store, 4 branch. A register specifier is 6 bits. Bit 5 set selects the FP file and bits 4:0 give the index, so the integer register 0 is 6'd0. A store carries its address base in src_a and its data in src_b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is waiting to issue |
| in_cls | input | 3 | Decoded class of the waiting instruction |
| in_dst | input | 6 | Destination register specifier |
| in_src_a | input | 6 | First source; the address base for loads and stores |
| in_src_b | input | 6 | Second source; the data operand for stores |
| stall | output | 1 | Hold the waiting instruction and send a bubble onward |
| issue | output | 1 | The waiting instruction leaves this cycle |

## Verification
The assertions assume that each waiting instruction has a class code from 0 to 4. They also assume that at most three producers with non-zero latency are in flight at once, which follows from single issue and a largest latency of 3. The stimulus is a fixed instruction sequence whose classes are all legal, issued one at a time. The bench holds each instruction at the input until it issues, so the table can never overfill. A store's address register is never the register produced just before it, except in the case that is there to check R5.

// File: rtl/ilk_pkg.sv
// Package: instruction classes and the pairwise producer latency table
// shared by the interlock and its checker.
package ilk_pkg;

    typedef enum logic [2:0] {
        CLS_INT    = 3'd0,
        CLS_FPALU  = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } ilk_cls_e;

    // Largest stall a producer can impose; sizes the counters.
    localparam int MAX_LAT = 3;

    // Stall cycles owed to an adjacent consumer reading as an ALU/address input.
    function automatic int lat_alu(ilk_cls_e c);
        case (c)
            CLS_FPALU: return 3;
            CLS_LOAD:  return 1;
            default:   return 0;
        endcase
    endfunction

    // Stall cycles owed to an adjacent store that uses the value as its data.
    function automatic int lat_sdata(ilk_cls_e c);
        case (c)
            CLS_FPALU: return 2;
            default:   return 0;
        endcase
    endfunction

    // Classes that write a destination register.
    function automatic logic writes_dst(ilk_cls_e c);
        return (c == CLS_INT) || (c == CLS_FPALU) || (c == CLS_LOAD);
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
// Producer table: one entry per in-flight producer holding its destination,
// class and a down-counter of remaining ALU-use stall cycles. An entry is
// live while its counter is non-zero. Assumes DEPTH >= MAX_LAT so that a
// free entry exists whenever a producer issues (single issue per cycle).
module ilk_scoreboard
    import ilk_pkg::*;
#(
    parameter int REG_W = 6,
    parameter int DEPTH = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             kill_en,
    input  logic [REG_W-1:0] new_dst,
    input  ilk_cls_e         new_cls,
    input  logic [CNT_W-1:0] new_lat,
    output logic [REG_W-1:0] ent_dst [DEPTH],
    output ilk_cls_e         ent_cls [DEPTH],
    output logic [CNT_W-1:0] ent_cnt [DEPTH]
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] free_idx;

    // Pick the lowest-numbered idle entry for the next allocation.
    always_comb begin
        logic found;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && ent_cnt[i] == '0) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Allocate, retire an older writer of the same register, or count down.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_cnt[g] <= '0;
                ent_dst[g] <= '0;
                ent_cls[g] <= CLS_INT;
            end else if (alloc_en && free_idx == IDX_W'(g)) begin
                ent_cnt[g] <= new_lat;
                ent_dst[g] <= new_dst;
                ent_cls[g] <= new_cls;
            end else if (kill_en && ent_cnt[g] != '0 && ent_dst[g] == new_dst) begin
                ent_cnt[g] <= '0;
            end else if (ent_cnt[g] != '0) begin
                ent_cnt[g] <= ent_cnt[g] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ilk_operand_check.sv
// Compares one source operand against every live producer entry and flags a
// hazard when the remaining count still exceeds the slack allowed for this
// kind of use. Assumes register specifier 0 is the hard-wired integer zero.
module ilk_operand_check
    import ilk_pkg::*;
#(
    parameter int REG_W = 6,
    parameter int DEPTH = 4,
    parameter int CNT_W = 2
) (
    input  logic             use_en,
    input  logic             sdata_use,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ent_dst [DEPTH],
    input  ilk_cls_e         ent_cls [DEPTH],
    input  logic [CNT_W-1:0] ent_cnt [DEPTH],
    output logic             hit
);
    // A match needs the full ALU count, or only the count above the store slack.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (use_en && src != '0 && ent_cnt[i] != '0 && ent_dst[i] == src) begin
                if (!sdata_use) begin
                    hit = 1'b1;
                end else if (int'(ent_cnt[i]) >
                             (lat_alu(ent_cls[i]) - lat_sdata(ent_cls[i]))) begin
                    hit = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ilk_issue_interlock.sv
// Issue interlock for an in-order single-issue pipeline. Decodes which
// operands the waiting instruction reads and how, checks them against the
// producer table, and holds the instruction until every required gap has
// elapsed. Assumes in_cls carries a legal class code.
module ilk_issue_interlock
    import ilk_pkg::*;
#(
    parameter int REG_W = 6,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_cls,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    output logic             stall,
    output logic             issue
);
    localparam int CNT_W  = $clog2(MAX_LAT + 1);
    localparam int N_OPND = 2;

    ilk_cls_e         cls;
    logic [REG_W-1:0] ent_dst [DEPTH];
    ilk_cls_e         ent_cls [DEPTH];
    logic [CNT_W-1:0] ent_cnt [DEPTH];
    logic [REG_W-1:0] op_src  [N_OPND];
    logic             op_en   [N_OPND];
    logic             op_sd   [N_OPND];
    logic             op_hit  [N_OPND];
    logic             kill_en;
    logic             alloc_en;

    assign cls = ilk_cls_e'(in_cls);

    // Operand decode: which sources are read, and whether as store data.
    always_comb begin
        op_src[0] = in_src_a;
        op_en[0]  = in_valid;
        op_sd[0]  = 1'b0;
        op_src[1] = in_src_b;
        op_en[1]  = in_valid && (cls != CLS_LOAD);
        op_sd[1]  = (cls == CLS_STORE);
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        ilk_operand_check #(
            .REG_W (REG_W),
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_chk (
            .use_en    (op_en[g]),
            .sdata_use (op_sd[g]),
            .src       (op_src[g]),
            .ent_dst   (ent_dst),
            .ent_cls   (ent_cls),
            .ent_cnt   (ent_cnt),
            .hit       (op_hit[g])
        );
    end

    // Hold on any operand hazard; otherwise let the instruction go.
    always_comb begin
        stall = 1'b0;
        for (int i = 0; i < N_OPND; i++) stall = stall | op_hit[i];
        issue = in_valid && !stall;
    end

    // Table update: the newest writer of a register replaces older ones.
    always_comb begin
        kill_en  = issue && writes_dst(cls) && (in_dst != '0);
        alloc_en = kill_en && (lat_alu(cls) != 0);
    end

    ilk_scoreboard #(
        .REG_W (REG_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc_en),
        .kill_en  (kill_en),
        .new_dst  (in_dst),
        .new_cls  (cls),
        .new_lat  (CNT_W'(lat_alu(cls))),
        .ent_dst  (ent_dst),
        .ent_cls  (ent_cls),
        .ent_cnt  (ent_cnt)
    );

endmodule

// File: rtl/ilk_issue_interlock_chk.sv
// Port-level checker for the issue interlock, attached through bind.
module ilk_issue_interlock_chk
    import ilk_pkg::*;
#(
    parameter int REG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_cls,
    input logic [REG_W-1:0] in_dst,
    input logic [REG_W-1:0] in_src_a,
    input logic [REG_W-1:0] in_src_b,
    input logic             stall,
    input logic             issue
);
    a_r10_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!stall && !issue));

    a_r7_zero_reg_free: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd0 && in_src_a == '0 && in_src_b == '0) |-> issue);

    a_r1_fp_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue) && $past(in_cls) == 3'd1 && $past(in_dst) != '0
         && in_valid && in_cls == 3'd1 && in_src_a == $past(in_dst)) |-> stall);

    a_r4_load_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue) && $past(in_cls) == 3'd2 && $past(in_dst) != '0
         && in_valid && in_cls == 3'd3 && in_src_b == $past(in_dst) && in_src_a == '0)
        |-> issue);

    a_r11_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && in_valid) |-> !stall);

endmodule

bind ilk_issue_interlock ilk_issue_interlock_chk #(.REG_W(REG_W)) u_ilk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_cls   (in_cls),
    .in_dst   (in_dst),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .stall    (stall),
    .issue    (issue)
);

// File: tb/ilk_issue_interlock_bench.sv
module ilk_issue_interlock_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_cls = 3'd0;
    logic [5:0] in_dst = '0;
    logic [5:0] in_src_a = '0;
    logic [5:0] in_src_b = '0;
    logic       stall;
    logic       issue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ilk_issue_interlock u_ilk_issue_interlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_cls   (in_cls),
        .in_dst   (in_dst),
        .in_src_a (in_src_a),
        .in_src_b (in_src_b),
        .stall    (stall),
        .issue    (issue)
    );

    // Vector fields: [22:20] class, [19:14] dst, [13:8] src_a, [7:2] src_b, [1:0] stalls.
    localparam int NV = 26;
    localparam logic [22:0] VEC [NV] = '{
        {3'd2, 6'd32, 6'd1,  6'd0,  2'd0},  // load F0
        {3'd1, 6'd36, 6'd32, 6'd34, 2'd1},  // R3 fp reads F0
        {3'd3, 6'd0,  6'd1,  6'd36, 2'd2},  // R2 store data F4
        {3'd0, 6'd1,  6'd1,  6'd0,  2'd0},  // R6 int producer
        {3'd4, 6'd0,  6'd1,  6'd2,  2'd0},  // R6 branch
        {3'd2, 6'd38, 6'd1,  6'd0,  2'd0},  // R6 delay slot
        {3'd3, 6'd0,  6'd1,  6'd38, 2'd0},  // R4 store data from load
        {3'd1, 6'd40, 6'd34, 6'd34, 2'd0},  // R8
        {3'd1, 6'd42, 6'd40, 6'd34, 2'd3},  // R1 adjacent
        {3'd1, 6'd44, 6'd34, 6'd34, 2'd0},  // R8
        {3'd0, 6'd3,  6'd4,  6'd5,  2'd0},  // R8
        {3'd3, 6'd0,  6'd1,  6'd44, 2'd1},  // R2 one apart
        {3'd2, 6'd6,  6'd2,  6'd0,  2'd0},  // load r6
        {3'd3, 6'd0,  6'd6,  6'd34, 2'd1},  // R5 address from load
        {3'd2, 6'd0,  6'd2,  6'd0,  2'd0},  // R7 load to r0
        {3'd0, 6'd7,  6'd0,  6'd0,  2'd0},  // R7 reads r0
        {3'd1, 6'd48, 6'd34, 6'd34, 2'd0},  // fp F16
        {3'd2, 6'd48, 6'd2,  6'd0,  2'd0},  // load F16 (newer)
        {3'd1, 6'd50, 6'd48, 6'd34, 2'd1},  // R9 newest wins
        {3'd2, 6'd52, 6'd2,  6'd0,  2'd0},  // load F20
        {3'd2, 6'd54, 6'd2,  6'd52, 2'd0},  // R12 load src_b ignored
        {3'd1, 6'd56, 6'd34, 6'd34, 2'd0},  // fp F24
        {3'd0, 6'd8,  6'd4,  6'd5,  2'd0},  // filler
        {3'd1, 6'd58, 6'd56, 6'd34, 2'd2},  // R1 one apart
        {3'd1, 6'd60, 6'd34, 6'd34, 2'd0},  // R8
        {3'd1, 6'd62, 6'd34, 6'd34, 2'd0}   // R8
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one instruction at a falling edge; count stall cycles until it issues.
    task automatic run_instr(input logic [2:0] c, input logic [5:0] d,
                             input logic [5:0] a, input logic [5:0] b,
                             output int nstall, output bit held_ok);
        @(negedge clk);
        in_valid = 1'b1; in_cls = c; in_dst = d; in_src_a = a; in_src_b = b;
        nstall = 0;
        held_ok = 1'b1;
        #1;
        while (stall && nstall < 20) begin
            if (issue) held_ok = 1'b0;
            nstall++;
            @(negedge clk);
            #1;
        end
        if (!issue) held_ok = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int  ns;
        bit  hok;
        // R11: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(stall == 1'b0 && issue == 1'b0, "R11 reset outputs", {stall, issue}, 0);
        rst_n = 1'b1;

        // Table of instructions walked in order.
        for (int i = 0; i < NV; i++) begin
            run_instr(VEC[i][22:20], VEC[i][19:14], VEC[i][13:8], VEC[i][7:2], ns, hok);
            check(ns == int'(VEC[i][1:0]), $sformatf("R1-table vec %0d stalls", i), ns,
                  int'(VEC[i][1:0]));
            check(hok, $sformatf("R10 held then issued vec %0d", i), 0, 1);
        end

        // R10: no stall when nothing is waiting, even with a matching source.
        run_instr(3'd1, 6'd33, 6'd34, 6'd34, ns, hok);
        @(negedge clk);
        in_valid = 1'b0; in_cls = 3'd1; in_dst = 6'd35; in_src_a = 6'd33; in_src_b = 6'd34;
        #1;
        check(stall == 1'b0 && issue == 1'b0, "R10 idle with hazard", {stall, issue}, 0);
        @(negedge clk);
        in_valid = 1'b1;
        #1;
        check(stall == 1'b1 && issue == 1'b0, "R10 R1 hazard once valid", {stall, issue}, 2);
        @(negedge clk);
        in_valid = 1'b0;

        // R11: reset empties the table mid-flight.
        run_instr(3'd1, 6'd39, 6'd34, 6'd34, ns, hok);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1; in_cls = 3'd1; in_dst = 6'd41; in_src_a = 6'd39; in_src_b = 6'd34;
        #1;
        check(stall == 1'b0 && issue == 1'b1, "R11 table cleared", {stall, issue}, 1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule